// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns a small group of external input pins into a single interrupt request line for a priority arbiter. Each pin is first brought into the clock domain through a multi-flop synchroniser. A select mask then picks which pins of the group take part. The levels of the selected pins are merged by a NAND, so the merged signal is low only when every selected pin is high.

A 2-bit sensitivity field decides how the merged signal becomes a request. In level mode the request follows the merged signal directly. In the three edge modes a detected edge is held in a latch, and that latch clears by itself when the processor enters the service routine and pulses the acknowledge input. A separate wake output tells the halt controller that a request is present, or is about to be latched, so the device can leave halt mode.

The asynchronous active-low reset is released synchronously inside the block, two clocks after the reset pin rises.

Top module: `ext_irq_cond`

## Requirements
- R1: While reset is applied, and after reset with all pins low and an empty mask, `irq_o` and `wake_o` are 0.
- R2: The merged signal is NOT(AND of the synchronised levels of the pins whose `sel_i` bit is 1). Pins whose bit is 0 have no effect.
- R3: With `sel_i` all zero the merged signal is held at 1. No pin activity then gives a level request or a new edge.
- R4: With `sense_i`=00 (low level), `irq_o` is 1 exactly while the merged signal is 0, and is not latched. `irq_o` changes 2 clock edges after a pin change, and `ack_i` has no effect.
- R5: With `sense_i`=01 a rising edge of the merged signal is latched. `irq_o` rises after the 3rd clock edge that follows the pin change.
- R6: With `sense_i`=10 a falling edge of the merged signal is latched, with the same latency as R5.
- R7: With `sense_i`=11 both edges of the merged signal are latched.
- R8: In an edge mode a latched request stays at 1 until `ack_i` is sampled high, and then reads 0 after that clock edge.
- R9: If a new edge is detected in the same cycle that `ack_i` is high, the latch stays set.
- R10: `wake_o` is 1 whenever `irq_o` is 1, and also in the cycle in which an edge is detected, which is one cycle before that edge shows on `irq_o`.
- R11: While `sense_i`=00 the edge latch is cleared. Leaving level mode therefore never shows a stale edge request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pins_i | input | NUM_PINS | Raw external pin levels of the group |
| sel_i | input | NUM_PINS | Pin select mask, 1 = pin takes part |
| sense_i | input | 2 | Sensitivity: 00 low level, 01 rising, 10 falling, 11 both |
| ack_i | input | 1 | Service-entry acknowledge, clears the edge latch |
| irq_o | output | 1 | Interrupt request to the arbiter |
| wake_o | output | 1 | Halt-mode wake indication |

## Verification
A latch that is wrongly set or cleared shows on `irq_o` on the clock edge after the faulty update, and it stays visible until the next acknowledge. Checking that output every cycle therefore exposes it at once. A wrong previous-sample register shows as a spurious or missing edge, one cycle early on `wake_o` and on the next cycle on `irq_o`. A synchroniser of the wrong depth moves every transition by a whole cycle against the computed schedule. The bench drives random pins, masks, modes and acknowledges and compares both outputs with a cycle model every cycle. Directed sequences place an acknowledge on the exact cycle of a new edge, empty the mask, and switch out of a latched edge mode.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW_LEVEL = 2'b00,
    SENSE_RISE      = 2'b01,
    SENSE_FALL      = 2'b10,
    SENSE_BOTH      = 2'b11
  } sense_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[LAST];

  initial begin
    assert (STAGES >= ext_irq_pkg::MIN_SYNC_STAGES)
      else $error("synchroniser needs at least two stages");
  end
endmodule

// File: rtl/ext_irq_combine.sv
module ext_irq_combine #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] sel_i,
  output logic             merged_o,
  output logic             any_sel_o
);
  logic [WIDTH-1:0] gated;

  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign gated[i] = sync_i[i] | ~sel_i[i];
  end

  always_comb begin
    any_sel_o = |sel_i;
    if (any_sel_o) begin
      merged_o = ~(&gated);
    end else begin
      merged_o = 1'b1;
    end
  end
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       merged_i,
  input  logic [1:0] sense_i,
  input  logic       ack_i,
  output logic       irq_o,
  output logic       wake_o
);
  sense_e mode;
  logic   is_level;
  logic   prev_q, prev_d;
  logic   lat_q, lat_d, lat_en;
  logic   rise, fall, hit;

  assign mode     = sense_e'(sense_i);
  assign is_level = (mode == SENSE_LOW_LEVEL);
  assign rise     = merged_i & ~prev_q;
  assign fall     = ~merged_i & prev_q;

  always_comb begin
    unique case (mode)
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    prev_d = merged_i;
    lat_en = is_level | hit | ack_i;
    if (is_level) begin
      lat_d = 1'b0;
    end else if (hit) begin
      lat_d = 1'b1;
    end else begin
      lat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  assign irq_o  = is_level ? ~merged_i : lat_q;
  assign wake_o = irq_o | hit;

  assert_edge_sets_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && hit) |=> lat_q);

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && lat_q && !ack_i) |=> lat_q);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && ack_i && !hit) |=> !lat_q);

  assert_edge_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && hit && ack_i) |=> lat_q);

  assert_level_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_level |=> !lat_q);

  assert_wake_leads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && !is_level && $past(!is_level)) |-> $past(wake_o));
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] sel_i,
  input  logic [1:0]          sense_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic                wake_o
);
  logic                rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0] pins_sync;
  logic                merged;
  logic                any_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  ext_irq_combine #(.WIDTH(NUM_PINS)) u_comb (
    .sync_i    (pins_sync),
    .sel_i     (sel_i),
    .merged_o  (merged),
    .any_sel_o (any_sel)
  );

  ext_irq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .merged_i (merged),
    .sense_i  (sense_i),
    .ack_i    (ack_i),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  assert_empty_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!any_sel && sense_i == 2'b00) |-> !irq_o);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> (!irq_o || sense_i == 2'b00));
endmodule

// File: tb/ext_irq_cond_test.sv
module ext_irq_cond_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pins_i, sel_i;
  logic [1:0]   sense_i;
  logic         ack_i;
  logic         irq_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N-1:0] m_s1, m_s2;
  logic         m_prev, m_lat;

  always #5 clk = ~clk;

  ext_irq_cond #(.NUM_PINS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sel_i(sel_i),
    .sense_i(sense_i), .ack_i(ack_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic f_merge(input logic [N-1:0] s, input logic [N-1:0] m);
    if (m == '0) return 1'b1;
    return ~(&(s | ~m));
  endfunction

  function automatic logic f_hit(input logic [1:0] md, input logic c, input logic p);
    case (md)
      2'b01:   return c & ~p;
      2'b10:   return ~c & p;
      2'b11:   return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic [N-1:0] p, input logic [N-1:0] m,
                       input logic [1:0] sn, input logic a, input string tag);
    logic c, h, e_irq, e_wake, n_lat;
    pins_i = p; sel_i = m; sense_i = sn; ack_i = a;
    #2;
    c = f_merge(m_s2, m);
    h = f_hit(sn, c, m_prev);
    e_irq  = (sn == 2'b00) ? ~c : m_lat;
    e_wake = e_irq | h;
    check(tag, "irq_o", irq_o, e_irq);
    check("R10", "wake_o", wake_o, e_wake);
    n_lat = (sn == 2'b00) ? 1'b0 : (h | (m_lat & ~a));
    @(posedge clk);
    #2;
    m_s2 = m_s1; m_s1 = p; m_prev = c; m_lat = n_lat;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pins_i = '0; sel_i = '0; sense_i = 2'b00; ack_i = 1'b0;
    m_s1 = '0; m_s2 = '0; m_prev = 1'b1; m_lat = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "irq_o in reset", irq_o, 1'b0);
    check("R1", "wake_o in reset", wake_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) cycle('0, '0, 2'b00, 1'b0, "R1");
    check("R1", "irq_o after reset", irq_o, 1'b0);

    // R2: select pins 0 and 1, level-low mode; pin 2 is unselected
    cycle(4'b0011, 4'b0011, 2'b00, 1'b0, "R2");
    cycle(4'b0011, 4'b0011, 2'b00, 1'b0, "R2");
    check("R2", "merged low after 2 edges", irq_o, 1'b1);
    cycle(4'b0111, 4'b0011, 2'b00, 1'b1, "R4");
    cycle(4'b0010, 4'b0011, 2'b00, 1'b0, "R2");
    cycle(4'b0010, 4'b0011, 2'b00, 1'b0, "R2");
    check("R2", "one selected pin low", irq_o, 1'b0);

    // R3: empty mask in level mode, pins toggling
    for (int i = 0; i < 6; i++) cycle(4'(i * 5), '0, 2'b00, 1'b0, "R3");

    // R5 / R9: pin0 only, merged = ~pin0; falling pin gives rising merged
    cycle(4'b0001, 4'b0001, 2'b01, 1'b0, "R5");
    repeat (3) cycle(4'b0001, 4'b0001, 2'b01, 1'b0, "R5");
    cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R5");
    cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R5");
    check("R5", "not yet latched", irq_o, 1'b0);
    cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R5");
    check("R5", "latched on 3rd edge", irq_o, 1'b1);
    repeat (4) cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R8");
    check("R8", "held without ack", irq_o, 1'b1);
    // new edge (merged falls then rises) coinciding with ack
    cycle(4'b0001, 4'b0001, 2'b01, 1'b0, "R9");
    repeat (2) cycle(4'b0001, 4'b0001, 2'b01, 1'b0, "R9");
    cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R9");
    cycle(4'b0000, 4'b0001, 2'b01, 1'b0, "R9");
    cycle(4'b0000, 4'b0001, 2'b01, 1'b1, "R9");
    check("R9", "edge with ack keeps latch", irq_o, 1'b1);
    cycle(4'b0000, 4'b0001, 2'b01, 1'b1, "R8");
    check("R8", "ack clears latch", irq_o, 1'b0);

    // R11: latch in both-edge mode, drop to level, come back
    cycle(4'b0001, 4'b0001, 2'b11, 1'b0, "R7");
    repeat (3) cycle(4'b0001, 4'b0001, 2'b11, 1'b0, "R7");
    check("R7", "falling merged latched", irq_o, 1'b1);
    cycle(4'b0000, 4'b0001, 2'b00, 1'b0, "R11");
    repeat (3) cycle(4'b0000, 4'b0001, 2'b00, 1'b0, "R11");
    cycle(4'b0000, 4'b0001, 2'b11, 1'b0, "R11");
    check("R11", "no stale request", irq_o, 1'b0);

    // R6: falling only
    cycle(4'b0000, 4'b0001, 2'b10, 1'b1, "R6");
    repeat (3) cycle(4'b0001, 4'b0001, 2'b10, 1'b0, "R6");
    check("R6", "falling merged latched", irq_o, 1'b1);

    // random mix
    begin
      logic [N-1:0] p, m;
      logic [1:0] sn;
      string tag;
      p = '0; m = 4'b0001; sn = 2'b01;
      for (int k = 0; k < 4000; k++) begin
        if ($urandom_range(0, 2) == 0) p = N'($urandom);
        if ($urandom_range(0, 40) == 0) m = N'($urandom);
        if ($urandom_range(0, 30) == 0) sn = 2'($urandom);
        if (m == '0) tag = "R3";
        else if (sn == 2'b00) tag = "R4";
        else if (sn == 2'b01) tag = "R5";
        else if (sn == 2'b10) tag = "R6";
        else tag = "R7";
        cycle(p, m, sn, ($urandom_range(0, 3) == 0), tag);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule